// File: doc/BRIEF.md
# Message-signalled interrupt collector

This block sits beside a PCIe host bridge and collects message-signalled interrupts into one interrupt line. An endpoint signals an interrupt by writing a vector number into a single doorbell register. The write sets that vector's pending flag. A flag is recorded whether or not the vector is currently allowed to interrupt, so a masked source never loses its event.

Software sees the pending flags as 32-bit words, one word per group of 32 vectors. It clears flags by writing ones to them. A second bank of 32-bit words, laid out the same way, holds one enable bit per vector. Software changes a single vector's mask with a read-modify-write of its enable word. The interrupt output is a register that is high whenever at least one vector is both pending and enabled.

The register port is a plain 32-bit bus with byte address, write strobe, write data and read data. Reads are combinational from the address.

Top module: `msi_irq_ctrl`

## Requirements
- R1: A write to byte offset 0x7C whose data value v is below 256 sets the pending flag of vector v on that clock edge.
- R2: Pending flag n is read as bit (n mod 32) of the word at byte offset 0x80 + 4*(n/32). There are eight such words, covering vectors 0 to 255.
- R3: Writing a status word clears exactly the flags whose data bits are 1. Flags written with 0 keep their value.
- R4: Enable bit n sits at bit (n mod 32) of the word at byte offset 0xA0 + 4*(n/32). The word reads back the last value written to it, and a 1 unmasks the vector.
- R5: While the synchronous, active-high reset is asserted, every pending flag and every enable bit is cleared and the interrupt output is low.
- R6: A doorbell write sets the pending flag even when the vector's enable bit is 0.
- R7: After each clock edge, the interrupt output is 1 exactly when some vector has both its pending flag and its enable bit set in the state updated at that edge.
- R8: A doorbell write whose data value is 256 or more changes no pending flag and no enable bit.
- R9: A read of the doorbell offset, or of any offset outside the status and enable words, returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 1 | Aggregated interrupt, registered |

## Verification
The bench rings the doorbell of a masked vector and expects the flag to be set with the interrupt still low. A design that gated the set with the enable bit would lose that event. It also rings vectors 0, 31, 32 and 255 and data values of 256 and above. A design that truncated the data to eight bits would raise a wrong flag, and a design with a wrong word or bit mapping would show the flag in the wrong place. Status writes that mix ones and zeros catch a design that cleared the whole word or used plain write semantics. Masking and clearing the last active vector catches an interrupt output that stays high one cycle too long or ignores the enable bits.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] en;
    } bank_state_t;

    typedef struct packed {
        logic irq;
    } top_state_t;
endpackage

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
    import msi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_bits,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic              en_we,
    input  logic [WORD_W-1:0] en_wdata,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] en_o,
    output logic              hit_next
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a set in the same cycle as a clear of the same bit wins
        st_d.pend = (st_q.pend & ~clr_bits) | set_bits;
        if (en_we) begin
            st_d.en = en_wdata;
        end
        hit_next = |(st_d.pend & st_d.en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int NUM_VEC  = 256,
    parameter int ADDR_W   = 8,
    parameter int DB_OFF   = 'h7C,
    parameter int STAT_OFF = 'h80,
    parameter int EN_OFF   = 'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    localparam int NWORDS = NUM_VEC / WORD_W;
    localparam int VEC_W  = $clog2(NUM_VEC);
    localparam int BIT_W  = $clog2(WORD_W);

    logic [NUM_VEC-1:0] pend_all;
    logic [NUM_VEC-1:0] en_all;
    logic [NWORDS-1:0]  hit_vec;
    logic [NWORDS-1:0]  stat_sel;
    logic [NWORDS-1:0]  en_sel;
    logic               db_valid;
    logic [VEC_W-1:0]   db_vec;

    assign db_valid = bus_we && (bus_addr == ADDR_W'(DB_OFF))
                      && (bus_wdata < 32'(NUM_VEC));
    assign db_vec   = bus_wdata[VEC_W-1:0];

    for (genvar w = 0; w < NWORDS; w++) begin : g_bank
        localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(STAT_OFF + 4 * w);
        localparam logic [ADDR_W-1:0] E_ADDR = ADDR_W'(EN_OFF + 4 * w);
        logic [WORD_W-1:0] set_w;
        logic [WORD_W-1:0] clr_w;

        assign stat_sel[w] = (bus_addr == S_ADDR);
        assign en_sel[w]   = (bus_addr == E_ADDR);
        assign set_w = (db_valid && ((db_vec >> BIT_W) == VEC_W'(w)))
                       ? (WORD_W'(1) << db_vec[BIT_W-1:0]) : '0;
        assign clr_w = (bus_we && stat_sel[w]) ? bus_wdata : '0;

        msi_vec_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_bits (set_w),
            .clr_bits (clr_w),
            .en_we    (bus_we && en_sel[w]),
            .en_wdata (bus_wdata),
            .pend_o   (pend_all[w*WORD_W +: WORD_W]),
            .en_o     (en_all[w*WORD_W +: WORD_W]),
            .hit_next (hit_vec[w])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (stat_sel[w]) bus_rdata = bus_rdata | pend_all[w*WORD_W +: WORD_W];
            if (en_sel[w])   bus_rdata = bus_rdata | en_all[w*WORD_W +: WORD_W];
        end
    end

    top_state_t top_d, top_q;

    always_comb begin
        top_d     = top_q;
        top_d.irq = |hit_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq_out = top_q.irq;
endmodule

// File: rtl/msi_irq_chk.sv
module msi_irq_chk #(
    parameter int NUM_VEC  = 256,
    parameter int ADDR_W   = 8,
    parameter int DB_OFF   = 'h7C,
    parameter int STAT_OFF = 'h80,
    parameter int EN_OFF   = 'hA0
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic               irq_out,
    input logic [NUM_VEC-1:0] pend_all,
    input logic [NUM_VEC-1:0] en_all
);
    localparam int VEC_W  = $clog2(NUM_VEC);
    localparam int NWORDS = NUM_VEC / 32;

    // R5
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_out && pend_all == '0 && en_all == '0));

    // R1
    db_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(DB_OFF) && bus_wdata < 32'(NUM_VEC))
        |=> pend_all[$past(bus_wdata[VEC_W-1:0])]);

    // R8
    db_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(DB_OFF) && bus_wdata >= 32'(NUM_VEC))
        |=> ($stable(pend_all) && $stable(en_all)));

    // R7
    irq_state_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(pend_all & en_all));

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        // R3
        w1c_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADDR_W'(STAT_OFF + 4 * w))
            |=> (pend_all[w*32 +: 32] == ($past(pend_all[w*32 +: 32]) & ~$past(bus_wdata))));
        // R4
        en_write_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_we && bus_addr == ADDR_W'(EN_OFF + 4 * w))
            |=> (en_all[w*32 +: 32] == $past(bus_wdata)));
    end
endmodule

bind msi_irq_ctrl msi_irq_chk #(
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W),
    .DB_OFF  (DB_OFF),
    .STAT_OFF(STAT_OFF),
    .EN_OFF  (EN_OFF)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .irq_out  (irq_out),
    .pend_all (pend_all),
    .en_all   (en_all)
);

// File: tb/sim_msi_irq_ctrl.sv
module sim_msi_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit mp [256];
    bit me [256];

    always #10 clk = ~clk;

    msi_irq_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit model_irq();
        for (int i = 0; i < 256; i++) if (mp[i] && me[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 2'b00)
            for (int b = 0; b < 32; b++) r[b] = mp[(a - 8'h80) / 4 * 32 + b];
        else if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 2'b00)
            for (int b = 0; b < 32; b++) r[b] = me[(a - 8'hA0) / 4 * 32 + b];
        return r;
    endfunction

    // per-cycle comparison of the interrupt output against the model (R7)
    always @(negedge clk) begin
        if (!rst) check(irq_out === model_irq(), "R7 irq", {31'b0, irq_out},
                        {31'b0, model_irq()});
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_we = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        for (int i = 0; i < 256; i++) begin mp[i] = 0; me[i] = 0; end
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        if (a == 8'h7C && d < 256) mp[d] = 1;
        if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 2'b00)
            for (int b = 0; b < 32; b++) if (d[b]) mp[(a - 8'h80) / 4 * 32 + b] = 0;
        if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 2'b00)
            for (int b = 0; b < 32; b++) me[(a - 8'hA0) / 4 * 32 + b] = d[b];
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #3;
        check(bus_rdata === model_read(a), tag, bus_rdata, model_read(a));
    endtask

    task automatic sweep(input string tag);
        for (int w = 0; w < 8; w++) rd(8'(8'h80 + 4 * w), tag);
        for (int w = 0; w < 8; w++) rd(8'(8'hA0 + 4 * w), tag);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R5: all words zero after reset, irq low
        sweep("R5 reset state");
        check(irq_out === 1'b0, "R5 irq after reset", {31'b0, irq_out}, 0);

        // R6: masked vector still records
        wr(8'h7C, 32'd5);
        rd(8'h80, "R6 masked doorbell sets pending");
        check(irq_out === 1'b0, "R6 masked no irq", {31'b0, irq_out}, 0);

        // R4 R7: unmask vector 5
        wr(8'hA0, 32'h0000_0020);
        rd(8'hA0, "R4 enable readback");
        check(irq_out === 1'b1, "R7 irq after unmask", {31'b0, irq_out}, 1);

        // R1 R2: mapping at word edges
        wr(8'h7C, 32'd0);
        wr(8'h7C, 32'd31);
        wr(8'h7C, 32'd32);
        wr(8'h7C, 32'd200);
        wr(8'h7C, 32'd255);
        sweep("R2 status mapping");
        rd(8'h9C, "R1 vector 255 at top word bit 31");

        // R8: out-of-range doorbell data
        wr(8'h7C, 32'd256);
        wr(8'h7C, 32'd300);
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h7C, 32'h0000_0105);
        sweep("R8 out-of-range ignored");

        // R9: doorbell and unmapped reads
        rd(8'h7C, "R9 doorbell read zero");
        rd(8'h40, "R9 unmapped read zero");
        rd(8'hC0, "R9 unmapped read zero");

        // R3: writing zeros keeps, ones clear selectively
        wr(8'h80, 32'h0);
        rd(8'h80, "R3 zero write keeps");
        wr(8'h80, 32'h0000_0001);
        rd(8'h80, "R3 partial clear");
        check(irq_out === 1'b1, "R7 irq held by vector 5", {31'b0, irq_out}, 1);
        wr(8'h80, 32'h0000_0020);
        check(irq_out === 1'b0, "R7 irq falls after clear", {31'b0, irq_out}, 0);

        // R4: read-modify-write mask on top word
        wr(8'hBC, 32'h8000_0000);
        check(irq_out === 1'b1, "R7 vector 255 unmasked", {31'b0, irq_out}, 1);
        rd(8'hBC, "R4 top enable word");
        v = bus_rdata & ~32'h8000_0000;
        wr(8'hBC, v);
        check(irq_out === 1'b0, "R7 irq falls after mask", {31'b0, irq_out}, 0);
        rd(8'h9C, "R6 pending kept while masked");

        // mixed traffic
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: wr(8'h7C, ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 299)));
                1: wr(8'(8'h80 + 4 * $urandom_range(0, 7)), $urandom & $urandom);
                2: wr(8'(8'hA0 + 4 * $urandom_range(0, 7)), $urandom & $urandom & $urandom);
                default: rd(8'(8'h80 + 4 * $urandom_range(0, 15)), "R2 R4 mixed read");
            endcase
        end
        sweep("R3 R4 after mixed traffic");

        // R5: reset in mid-run
        for (int w = 0; w < 8; w++) wr(8'(8'hA0 + 4 * w), 32'hFFFF_FFFF);
        wr(8'h7C, 32'd77);
        check(irq_out === 1'b1, "R7 before reset", {31'b0, irq_out}, 1);
        do_reset();
        check(irq_out === 1'b0, "R5 irq cleared", {31'b0, irq_out}, 0);
        sweep("R5 state cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule